// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block holds the interrupt flags of a stand-alone CAN controller. There are five flags: receive, transmit, error, data overrun and wake-up. The controller core supplies level status signals: receive FIFO non-empty, transmit buffer released, error status, bus status, data overrun status and sleep mode. It also supplies a strobe for the receive-buffer release command, a strobe for a sleep request, and a bus-activity level.

The block watches each status for the condition that belongs to its source:

- a rising edge sets the receive, transmit and overrun flags;
- a change in either direction sets the error flag;
- a falling edge of sleep mode sets the wake-up flag.

Four enable bits gate the receive, transmit, error and overrun sources. Wake-up is never gated.

The host reads the register through a simple read port at one fixed address. The read returns the flags as they stood before the read, and the same read clears all of them. A single registered active-low output tells the host that some flag is pending.

Top module: `can_irq_flags`

## Requirements
- R1: After synchronous reset all flags are 0, `irq_n` is 1 and `rd_data` is 0.
- R2: A read at address 3 returns the flags in `rd_data` on the next cycle, using these bit positions: receive in bit 0, transmit in bit 1, error in bit 2, overrun in bit 3 and wake-up in bit 4. The returned values are those before the clear. Bits 7 to 5 always read as 1.
- R3: A read at address 3 clears every flag that has no set event in the same cycle. A read at any other address returns 0 and leaves the flags unchanged.
- R4: `irq_n` is 0 exactly while at least one flag is set. It changes on the same edge as the flags.
- R5: The receive flag sets when `rx_nonempty` rises while `irq_en[0]` is 1. A FIFO that stays non-empty does not set the flag again after a read.
- R6: A `rx_release` strobe while `rx_nonempty` is 1 and `irq_en[0]` is 1 sets the receive flag again. `rx_nonempty` is taken to show the FIFO state after the release.
- R7: The transmit flag sets when `tx_released` rises while `irq_en[1]` is 1.
- R8: The error flag sets on any change of `err_status` or `bus_status`, in either direction, while `irq_en[2]` is 1.
- R9: The overrun flag sets when `overrun_status` rises while `irq_en[3]` is 1. It sets on the first edge at which the high status is sampled.
- R10: The wake-up flag sets when `sleep_mode` falls, whatever the enables are.
- R11: A `sleep_req` strobe sets the wake-up flag when `bus_active` is 1 or any flag is pending. Otherwise the strobe has no effect.
- R12: When a set event and a clearing read fall in the same cycle, the read returns the old flag and the flag is set afterwards.
- R13: A source event whose enable bit is 0 leaves its flag clear and `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_nonempty | input | 1 | Receive FIFO holds at least one message |
| tx_released | input | 1 | Transmit buffer released |
| err_status | input | 1 | Error status level |
| bus_status | input | 1 | Bus status level |
| overrun_status | input | 1 | Data overrun status level |
| sleep_mode | input | 1 | Controller is in sleep mode |
| rx_release | input | 1 | Release-receive-buffer command strobe |
| sleep_req | input | 1 | Host sleep request strobe |
| bus_active | input | 1 | Bus activity in progress |
| irq_en | input | 4 | Enables: 0 receive, 1 transmit, 2 error, 3 overrun |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a set event landing in the same cycle as a clearing read. The bench raises `tx_released` in exactly the cycle it issues the read, then reads again to show that the transmit flag survived.

A second hard case is telling a FIFO that stays non-empty apart from a real re-arm. The bench holds `rx_nonempty` high across a read and several idle cycles and expects nothing. It then pulses `rx_release` with the FIFO still non-empty and expects the flag back.

A sweep over all 16 enable patterns, crossed with every source, covers the gating.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NFLAG    = 5;
  localparam int NGATED   = 4;
  localparam int IDX_RX   = 0;
  localparam int IDX_TX   = 1;
  localparam int IDX_ERR  = 2;
  localparam int IDX_OVR  = 3;
  localparam int IDX_WAKE = 4;

  typedef struct packed {
    logic rx_ne;
    logic tx_rel;
    logic err_st;
    logic bus_st;
    logic ovr_st;
    logic sleep;
  } core_status_t;
endpackage

// File: rtl/can_irq_events.sv
module can_irq_events
  import can_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  core_status_t       st_i,
  input  logic               rx_release_i,
  input  logic               sleep_req_i,
  input  logic               bus_active_i,
  input  logic               pending_i,
  input  logic [NGATED-1:0]  en_i,
  output logic [NFLAG-1:0]   set_o
);
  core_status_t st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_i;
  end

  logic rx_rise, tx_rise, ovr_rise, err_chg, sleep_exit, sleep_refused;

  always_comb begin
    rx_rise       = st_i.rx_ne  & ~st_q.rx_ne;
    tx_rise       = st_i.tx_rel & ~st_q.tx_rel;
    ovr_rise      = st_i.ovr_st & ~st_q.ovr_st;
    err_chg       = (st_i.err_st ^ st_q.err_st) | (st_i.bus_st ^ st_q.bus_st);
    sleep_exit    = st_q.sleep & ~st_i.sleep;
    sleep_refused = sleep_req_i & (bus_active_i | pending_i);

    set_o           = '0;
    set_o[IDX_RX]   = en_i[IDX_RX]  & (rx_rise | (rx_release_i & st_i.rx_ne));
    set_o[IDX_TX]   = en_i[IDX_TX]  & tx_rise;
    set_o[IDX_ERR]  = en_i[IDX_ERR] & err_chg;
    set_o[IDX_OVR]  = en_i[IDX_OVR] & ovr_rise;
    set_o[IDX_WAKE] = sleep_exit | sleep_refused;
  end

  // R13: a source whose enable is low never produces a set event
  p_gate_r13: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0 && !st_q.sleep && !sleep_req_i) |-> (set_o == '0));
endmodule

// File: rtl/can_irq_flag.sv
module can_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R12: a set event wins over a simultaneous clear
  p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R3: a clear without a set event empties the flag
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  // R5: without a set event or a clear the flag keeps its value
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int IRQ_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_nonempty,
  input  logic              tx_released,
  input  logic              err_status,
  input  logic              bus_status,
  input  logic              overrun_status,
  input  logic              sleep_mode,
  input  logic              rx_release,
  input  logic              sleep_req,
  input  logic              bus_active,
  input  logic [3:0]        irq_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int              RSVD_W  = DATA_W - NFLAG;
  localparam logic [ADDR_W-1:0] SEL   = IRQ_ADDR[ADDR_W-1:0];

  core_status_t     st;
  logic [NFLAG-1:0] set_ev, flags_q, flags_d;
  logic             rd_hit;

  assign st = '{rx_ne: rx_nonempty, tx_rel: tx_released, err_st: err_status,
                bus_st: bus_status, ovr_st: overrun_status, sleep: sleep_mode};
  assign rd_hit = rd_en && (rd_addr == SEL);

  can_irq_events u_events (
    .clk          (clk),
    .rst          (rst),
    .st_i         (st),
    .rx_release_i (rx_release),
    .sleep_req_i  (sleep_req),
    .bus_active_i (bus_active),
    .pending_i    (|flags_q),
    .en_i         (irq_en[NGATED-1:0]),
    .set_o        (set_ev)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    can_irq_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_ev[i]),
      .clr_i (rd_hit),
      .q_o   (flags_q[i])
    );
  end

  assign flags_d = set_ev | (flags_q & ~{NFLAG{rd_hit}});

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n   <= 1'b1;
      rd_data <= '0;
    end else begin
      irq_n   <= ~|flags_d;
      rd_data <= rd_hit ? {{RSVD_W{1'b1}}, flags_q} : '0;
    end
  end

  // R4: the request line tracks the flag set
  p_irq_match_r4: assert property (@(posedge clk) disable iff (rst)
    irq_n == (flags_q == '0));
  // R2: read data shows the pre-clear flags with reserved bits high
  p_rd_data_r2: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data == {{RSVD_W{1'b1}}, $past(flags_q)}));
  // R3: reads elsewhere return zero
  p_other_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hit) |=> (rd_data == '0));
  // R3: a read with no set event leaves no flag behind
  p_rd_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && set_ev == '0) |=> (flags_q == '0));
endmodule

// File: tb/can_irq_flags_bench.sv
module can_irq_flags_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxne = 0, tx = 0, err = 0, bus = 0, ovr = 0, slp = 0;
  logic rel = 0, sreq = 0, bact = 0, rd = 0;
  logic [3:0] en = 4'h0;
  logic [4:0] addr = 5'd0;
  logic [7:0] rd_data;
  logic irq_n;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur = "R1";

  // bench-side expectation state
  logic [4:0] exp_f = '0;
  logic [7:0] exp_rd = '0;
  logic p_rxne = 0, p_tx = 0, p_err = 0, p_bus = 0, p_ovr = 0, p_slp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_flags u_can_irq_flags (
    .clk(clk), .rst(rst), .rx_nonempty(rxne), .tx_released(tx),
    .err_status(err), .bus_status(bus), .overrun_status(ovr),
    .sleep_mode(slp), .rx_release(rel), .sleep_req(sreq),
    .bus_active(bact), .irq_en(en), .rd_en(rd), .rd_addr(addr),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic chk(string what, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", cur, what, act, expv);
    end
  endtask

  task automatic cyc();
    logic [4:0] ev;
    logic hit;
    @(posedge clk);
    if (rst) begin
      exp_f = '0; exp_rd = '0;
      {p_rxne, p_tx, p_err, p_bus, p_ovr, p_slp} = '0;
    end else begin
      ev[0] = en[0] && ((rxne && !p_rxne) || (rel && rxne));
      ev[1] = en[1] && tx && !p_tx;
      ev[2] = en[2] && ((err != p_err) || (bus != p_bus));
      ev[3] = en[3] && ovr && !p_ovr;
      ev[4] = (p_slp && !slp) || (sreq && (bact || exp_f != 0));
      hit = rd && (addr == 5'd3);
      exp_rd = hit ? {3'b111, exp_f} : 8'h00;
      exp_f = ev | (hit ? 5'b0 : exp_f);
      {p_rxne, p_tx, p_err, p_bus, p_ovr, p_slp} = {rxne, tx, err, bus, ovr, slp};
    end
    @(negedge clk);
    chk("rd_data", rd_data, exp_rd);
    chk("irq_n", {7'b0, irq_n}, {7'b0, exp_f == 0});
  endtask

  task automatic rd_at(logic [4:0] a);
    rd = 1; addr = a; cyc(); rd = 0; addr = 0;
  endtask

  task automatic drive(int s, logic v);
    case (s)
      0: rxne = v;
      1: tx   = v;
      2: err  = v;
      3: ovr  = v;
      4: slp  = v;
      default: bus = v;
    endcase
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rst = 0;
    cur = "R1"; cyc(); cyc();

    // sweep: every enable pattern against every source (R7 R8 R9 R10 R13)
    for (int e = 0; e < 16; e++) begin
      en = 4'(e);
      for (int s = 0; s < 6; s++) begin
        case (s)
          0: cur = "R5";  1: cur = "R7";  2: cur = "R8";
          3: cur = "R9";  4: cur = "R10"; default: cur = "R8";
        endcase
        if (e == 0) cur = "R13";
        drive(s, 1); cyc(); cyc();
        drive(s, 0); cyc();
        cur = "R2"; rd_at(5'd3);
        cur = "R3"; rd_at(5'd3);
      end
    end

    en = 4'hF;
    // R5: FIFO staying non-empty does not re-arm after a read
    cur = "R5"; rxne = 1; cyc(); rd_at(5'd3); cyc(); cyc(); cyc(); rd_at(5'd3);
    // R6: release with message remaining re-arms
    cur = "R6"; rel = 1; cyc(); rel = 0; cyc(); rd_at(5'd3);
    // R13: release with receive disabled
    cur = "R13"; en = 4'hE; rel = 1; cyc(); rel = 0; cyc(); rd_at(5'd3);
    en = 4'hF; rxne = 0; cyc(); rd_at(5'd3);

    // R12: event in the read cycle survives the read
    cur = "R12"; rd = 1; addr = 5'd3; tx = 1; cyc(); rd = 0; addr = 0;
    cyc(); rd_at(5'd3); tx = 0; cyc();

    // R3: read at another address leaves the flags
    cur = "R3"; tx = 1; cyc(); tx = 0; rd_at(5'd5); rd_at(5'd2); cyc(); rd_at(5'd3);

    // R11: refused sleep request
    cur = "R11"; bact = 1; sreq = 1; cyc(); sreq = 0; bact = 0; rd_at(5'd3);
    sreq = 1; cyc(); sreq = 0; cyc(); rd_at(5'd3);
    ovr = 1; cyc(); ovr = 0; sreq = 1; cyc(); sreq = 0; rd_at(5'd3);

    // R4 R1: final idle and reset
    cur = "R4"; cyc(); cyc();
    rst = 1; cur = "R1"; cyc(); rst = 0; cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule